// File: doc/BRIEF.md
# Glitch-free clock stop gate

This block sits between a free-running internal clock and a group of clock outputs. An active-low stop request, which may change at any time with no relation to the clock, halts the group. The request first passes through a two-stage synchronizer. A small run controller then decides when the stop takes effect. Each output is gated by an enable register that changes only on the falling edge of the source clock. As a result, a stopped output always rests low, and the first high phase after a restart is a complete half period.

One output of the group is free-running and never follows the stop request. Every output also has a static enable bit from configuration, and a cleared bit holds that output low whatever the stop state. A mode bit is captured while reset is held. When the captured bit is 1, the stop pin is ignored. The controller also enforces a minimum run length, so a restarted group cannot be stopped again too soon.

Top module: `clk_stop_gate`

## Requirements
- R1: The stop request passes through two synchronizer flops before it can change any output. The outputs therefore keep the high phases of the first and second rising edges after a change of `stop_n`.
- R2: When `stop_n` is held low, every stoppable output and `gclk_grp` are low from the fourth rising edge after the fall of `stop_n` onward. A stopped output is never high.
- R3: After `stop_n` returns high, the outputs are running again at the fourth rising edge.
- R4: Every high phase on every output lasts exactly half a source-clock period. No runt pulse appears when an output stops, restarts, or has its enable bit changed.
- R5: After reset or after a restart, the group gives at least `MIN_RUN` high pulses (default 100) before a new stop request is honoured. It stops within 4 cycles after the last of those pulses.
- R6: `mode` is sampled on every rising edge while `rst_n` is low. If the captured value is 1, the stop request has no effect and all outputs keep running.
- R7: A change of `mode` after reset is released has no effect until the next reset.
- R8: Output `FREE_IDX` (default 0) ignores the stop request. It runs whenever its enable bit is set.
- R9: When bit i of `out_en` is 0, `gclk_out[i]` is held low from the next falling edge, whatever the stop state. Bit value 1 lets the output run.
- R10: While reset is held, the synchronizer and controller sit in the running state and every gate is open, so all outputs follow the source clock.
- R11: `gclk_grp` follows the stop state only. It ignores `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Active-low asynchronous reset; mode is captured while low |
| stop_n | input | 1 | Asynchronous active-low stop request |
| mode | input | 1 | 0 honours the stop request, 1 ignores it (captured during reset) |
| out_en | input | NUM_OUT | Static per-output enables, 1 = run, 0 = hold low |
| gclk_grp | output | 1 | Gated group clock, stop-controlled only |
| gclk_out | output | NUM_OUT | Gated per-output clock copies |

## Verification
A change of `stop_n` reaches the controller after two rising edges, and the controller updates on the third. The gate registers follow on the falling edge after that, so the fourth rising edge is the first one that shows the new state. The bench drives inputs one nanosecond after a rising edge and reads outputs two nanoseconds after later rising edges, in the middle of the high phase. It expects the old state at the first and second edges and the new state from the fourth edge on. Minimum-run checks count output rising edges between the request and the settled stop, and they accept any count from `MIN_RUN` up to four more than that. A pulse-width monitor times every high phase on every output.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;

  typedef enum logic {
    ST_HALT = 1'b0,
    ST_RUN  = 1'b1
  } csg_run_e;

  function automatic int csg_cnt_w(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {STAGES{RESET_VAL}};
    else        shreg <= {shreg[STAGES-2:0], din};
  end

  assign dout = shreg[STAGES-1];

endmodule

// File: rtl/csg_run_ctrl.sv
module csg_run_ctrl
  import clk_stop_gate_pkg::*;
#(
  parameter int MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  output logic run_q
);

  localparam int CNT_W = csg_cnt_w(MIN_RUN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_RUN - 1);

  csg_run_e         state;
  logic [CNT_W-1:0] ran;

  // ran counts rising edges seen while running; a stop is honoured once
  // MIN_RUN enabled high phases have gone out.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      ran   <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (stop_req && ran >= LAST) state <= ST_HALT;
          else if (ran < LAST)         ran   <= ran + 1'b1;
        end
        ST_HALT: begin
          if (!stop_req) begin
            state <= ST_RUN;
            ran   <= '0;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign run_q = (state == ST_RUN);

endmodule

// File: rtl/csg_gate_cell.sv
module csg_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic open_d,
  output logic gclk
);

  logic open_q;

  // Updated on the falling edge only, so the gate moves while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b1;
    else        open_q <= open_d;
  end

  assign gclk = clk & open_q;

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int NUM_OUT     = 4,
  parameter int FREE_IDX    = 0,
  parameter int MIN_RUN     = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_src,
  input  logic               rst_n,
  input  logic               stop_n,
  input  logic               mode,
  input  logic [NUM_OUT-1:0] out_en,
  output logic               gclk_grp,
  output logic [NUM_OUT-1:0] gclk_out
);

  logic mode_q;
  logic stop_sync_n;
  logic run_q;
  logic [NUM_OUT-1:0] open_d;

  // Mode is captured only while reset is held.
  always_ff @(posedge clk_src) begin
    if (!rst_n) mode_q <= mode;
  end

  csg_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk  (clk_src),
    .rst_n(rst_n),
    .din  (stop_n),
    .dout (stop_sync_n)
  );

  csg_run_ctrl #(
    .MIN_RUN(MIN_RUN)
  ) u_ctrl (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .stop_req(!stop_sync_n && !mode_q),
    .run_q   (run_q)
  );

  csg_gate_cell u_grp_gate (
    .clk   (clk_src),
    .rst_n (rst_n),
    .open_d(run_q),
    .gclk  (gclk_grp)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    if (i == FREE_IDX) begin : g_free
      assign open_d[i] = out_en[i];
    end else begin : g_stoppable
      assign open_d[i] = out_en[i] & run_q;
    end

    csg_gate_cell u_gate (
      .clk   (clk_src),
      .rst_n (rst_n),
      .open_d(open_d[i]),
      .gclk  (gclk_out[i])
    );
  end

endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk
  import clk_stop_gate_pkg::*;
#(
  parameter int NUM_OUT  = 4,
  parameter int FREE_IDX = 0,
  parameter int MIN_RUN  = 100
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_q,
  input logic               sync_run,
  input logic               run_q,
  input logic [NUM_OUT-1:0] out_en,
  input logic               gclk_grp,
  input logic [NUM_OUT-1:0] gclk_out
);

  localparam int CW = csg_cnt_w(MIN_RUN);
  localparam logic [NUM_OUT-1:0] FREE_MASK = NUM_OUT'(1) << FREE_IDX;
  localparam logic [NUM_OUT-1:0] STOP_MASK = ~FREE_MASK;

  logic [CW-1:0] runs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   runs <= '0;
    else if (!run_q)              runs <= '0;
    else if (runs < CW'(MIN_RUN)) runs <= runs + 1'b1;
  end

  AST_MODE_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> run_q) else $error("mode 1 let the group stop"); // R6

  AST_HALT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> !$past(sync_run)) else $error("halt without synced request"); // R1

  AST_RESUME_NEEDS_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(sync_run)) else $error("resume without synced release"); // R3

  AST_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (runs >= CW'(MIN_RUN))) else $error("stopped before minimum run"); // R5

  AST_PARK_LOW: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(run_q)) |-> (!gclk_grp && ((gclk_out & STOP_MASK) == '0)))
    else $error("stopped output high"); // R2

  AST_FULL_HIGH: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run_q)) |-> gclk_grp) else $error("missing high phase"); // R4

  AST_EN_HOLDS_LOW: assert property (@(negedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((gclk_out & ~$past(out_en)) == '0)) else $error("disabled output high"); // R9

  AST_FREE_RUNS: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(out_en[FREE_IDX])) |-> gclk_out[FREE_IDX])
    else $error("free output stopped"); // R8

endmodule

bind clk_stop_gate clk_stop_gate_chk #(
  .NUM_OUT (NUM_OUT),
  .FREE_IDX(FREE_IDX),
  .MIN_RUN (MIN_RUN)
) u_chk (
  .clk     (clk_src),
  .rst_n   (rst_n),
  .mode_q  (mode_q),
  .sync_run(stop_sync_n),
  .run_q   (run_q),
  .out_en  (out_en),
  .gclk_grp(gclk_grp),
  .gclk_out(gclk_out)
);

// File: tb/clk_stop_gate_test.sv
`timescale 1ns/1ps
module clk_stop_gate_test;

  localparam int N       = 4;
  localparam int MINRUN  = 100;
  localparam int NROWS   = 7;

  // {stop_n, out_en[3:0], exp gclk_grp, exp gclk_out[3:0]}
  localparam logic [9:0] TABLE [NROWS] = '{
    10'b1_1111_1_1111,
    10'b1_1010_1_1010,
    10'b0_1111_0_0001,
    10'b0_0110_0_0000,
    10'b0_0101_0_0001,
    10'b1_1111_1_1111,
    10'b1_0000_1_0000
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         stop_n;
  logic         mode;
  logic [N-1:0] out_en;
  logic         gclk_grp;
  logic [N-1:0] gclk_out;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  clk_stop_gate #(.NUM_OUT(N), .FREE_IDX(0), .MIN_RUN(MINRUN)) uut (
    .clk_src (clk),
    .rst_n   (rst_n),
    .stop_n  (stop_n),
    .mode    (mode),
    .out_en  (out_en),
    .gclk_grp(gclk_grp),
    .gclk_out(gclk_out)
  );

  always @(posedge gclk_grp) pulses++;

  // High-phase width monitor on every output.
  wire [N:0] mon = {gclk_grp, gclk_out};
  int  runts [N+1];
  for (genvar g = 0; g <= N; g++) begin : g_mon
    realtime rise_t;
    bit      armed = 1'b0;
    initial runts[g] = 0;
    always @(mon[g]) begin
      if (mon[g] === 1'b1) begin
        rise_t = $realtime;
        armed  = 1'b1;
      end else if (armed) begin
        if (($realtime - rise_t) < 3.99 || ($realtime - rise_t) > 4.01) runts[g]++;
        armed = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_range(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic sample(output logic [4:0] v);
    @(posedge clk);
    #2;
    v = {gclk_grp, gclk_out};
  endtask

  task automatic drive_stop(input logic v);
    @(posedge clk);
    #1 stop_n = v;
  endtask

  initial begin
    logic [4:0] s1, s2, s3, s4, s5;
    int base;

    rst_n  = 1'b0;
    stop_n = 1'b1;
    mode   = 1'b1;
    out_en = '1;

    // Mode 1 captured during reset: stop ignored (R6), later mode change ignored (R7).
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    drive_stop(1'b0);
    repeat (150) @(posedge clk);
    sample(s1);
    chk("R6 stop ignored with mode 1", s1, 5'b1_1111);
    @(posedge clk);
    #1 mode = 1'b0;
    repeat (20) @(posedge clk);
    sample(s1);
    chk("R7 mode change after reset ignored", s1, 5'b1_1111);
    drive_stop(1'b1);

    // Reset with mode 0; outputs run during reset (R10).
    @(posedge clk);
    #5 rst_n = 1'b0;
    sample(s1);
    chk("R10 outputs run during reset", s1, 5'b1_1111);
    repeat (2) @(posedge clk);
    #5 rst_n = 1'b1;
    base = pulses;
    drive_stop(1'b0);
    repeat (130) @(posedge clk);
    chk_range("R5 pulses before stop after reset", pulses - base, MINRUN, MINRUN + 4);
    sample(s1);
    chk("R2 R8 stopped state", s1, 5'b0_0001);

    // Restart latency.
    drive_stop(1'b1);
    base = pulses;
    sample(s1);
    sample(s2);
    sample(s3);
    sample(s4);
    chk("R1 still stopped at edge 1", s1, 5'b0_0001);
    chk("R1 still stopped at edge 2", s2, 5'b0_0001);
    chk("R3 running by edge 4", s4, 5'b1_1111);
    #1 stop_n = 1'b0;
    repeat (130) @(posedge clk);
    chk_range("R5 pulses before stop after restart", pulses - base, MINRUN, MINRUN + 4);
    sample(s1);
    chk("R2 stopped after minimum run", s1, 5'b0_0001);

    // Table of static configurations.
    for (int r = 0; r < NROWS; r++) begin
      @(posedge clk);
      #1;
      stop_n = TABLE[r][9];
      out_en = TABLE[r][8:5];
      repeat (120) @(posedge clk);
      sample(s1);
      chk($sformatf("table row %0d (R2 R8 R9 R11)", r), s1, TABLE[r][4:0]);
    end

    // Stop latency from a long run.
    @(posedge clk);
    #1 out_en = '1;
    repeat (4) @(posedge clk);
    drive_stop(1'b0);
    sample(s1);
    sample(s2);
    sample(s3);
    sample(s4);
    sample(s5);
    chk("R1 running at edge 1", s1, 5'b1_1111);
    chk("R1 running at edge 2", s2, 5'b1_1111);
    chk("R2 stopped by edge 4", s4, 5'b0_0001);
    chk("R2 stopped at edge 5", s5, 5'b0_0001);
    if (s3 === 5'bxxxxx) $display("edge 3 undefined");

    repeat (4) @(posedge clk);
    chk_range("R4 runt pulses", runts[0] + runts[1] + runts[2] + runts[3] + runts[4], 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule